// File: doc/BRIEF.md
# Vector Lane Compare-Select Unit

This unit is the compare-and-select stage of a SIMD datapath with a parameterised number of lanes (eight by default) of 16-bit two's-complement data. One strobed operation applies a single op code to two source vectors, `s` and `t`. In every lane it forms a compare bit and uses that bit, or a fixed rule, to pick the lane value from `s` or `t`. The picked vector goes to the destination output and to the low slice of the accumulator in the same clock edge.

Each lane owns four flag bits: not-equal, carry, compare and clip. The ordered compares consult the stored not-equal and carry bits to settle a lane whose operands are equal. Every compare then clears not-equal, carry and clip and stores its new compare bit. The merge operation needs no new comparison. It selects with the compare bits already stored. Other parts of the datapath, such as the clip instructions, produce the flags. They hand them over through a flag-load port, so this unit does not compute them.

Top module: `vcs_unit`

## Requirements
- R1: Op code 3'd4 (merge) writes each lane from `s` where that lane's stored compare flag is 1 and from `t` where it is 0, and leaves all four flag vectors unchanged.
- R2: Op code 3'd0 (less-than) sets a lane's compare bit when s < t (signed), or when s == t and both the stored not-equal and carry flags of that lane are 1. The lane result is s if the new bit is 1, else t.
- R3: Op code 3'd3 (greater-or-equal) sets a lane's compare bit when s > t (signed), or when s == t and not both the stored not-equal and carry flags are 1. The lane result is s if the new bit is 1, else t.
- R4: Op code 3'd1 (equal) sets a lane's compare bit when s == t and the stored not-equal flag is 0. The result vector is always t.
- R5: Op code 3'd2 (not-equal) sets a lane's compare bit when s != t or the stored not-equal flag is 1. The result vector is always s.
- R6: After any of op codes 0 to 3, the not-equal, carry and clip flags of every lane read 0, and the compare flags hold the new compare bits.
- R7: A legal operation with `in_valid` high commits on that clock edge. Both `dst_out` and `acc_lo_out` show the result after that edge. With `in_valid` low, both hold their value.
- R8: Op codes 3'd5 to 3'd7 are reserved. A strobe carrying one of them changes no output and no flag.
- R9: With `flag_load` high and `in_valid` low, the four flag vectors load from the flag inputs on the clock edge. When `in_valid` is high, `flag_load` is ignored.
- R10: A synchronous active-high `rst` clears all flag vectors, `dst_out` and `acc_lo_out`.
- R11: Lane i occupies bits [16i+15:16i] of every data vector, and bit i of every flag vector belongs to lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Op code (0 lt, 1 eq, 2 ne, 3 ge, 4 merge) |
| src_s | input | LANES*W | Source vector s |
| src_t | input | LANES*W | Source vector t |
| flag_load | input | 1 | Load the flag vectors from the flag inputs |
| flag_ne_in | input | LANES | Not-equal flags to load |
| flag_co_in | input | LANES | Carry flags to load |
| flag_cmp_in | input | LANES | Compare flags to load |
| flag_clip_in | input | LANES | Clip flags to load |
| dst_out | output | LANES*W | Destination vector |
| acc_lo_out | output | LANES*W | Accumulator low slice |
| ne_flags | output | LANES | Stored not-equal flags |
| co_flags | output | LANES | Stored carry flags |
| cmp_flags | output | LANES | Stored compare flags |
| clip_flags | output | LANES | Stored clip flags |

## Verification
Each result and flag update is due exactly one clock edge after a strobe or flag load. The bench drives inputs on a falling edge. It drops the strobe on the next falling edge and reads the outputs at that same moment, half a period after the committing rising edge. Flag preloads take their own edge before each operation, so the tie-break always sees known stored flags. Reserved op codes and ignored loads are checked on the following falling edge by comparing every output with the value it held before.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    typedef enum logic [2:0] {
        OP_LT  = 3'd0,
        OP_EQ  = 3'd1,
        OP_NE  = 3'd2,
        OP_GE  = 3'd3,
        OP_MRG = 3'd4
    } vcs_op_e;

    typedef struct packed {
        logic ne;
        logic co;
        logic cmp;
        logic clip;
    } lane_flag_t;

    function automatic logic op_is_legal(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

    function automatic logic op_is_cmp(input logic [2:0] op);
        return op <= 3'd3;
    endfunction

endpackage

// File: rtl/vcs_lane.sv
module vcs_lane
    import vcs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] s,
    input  logic [W-1:0] t,
    input  lane_flag_t   fl,
    output logic         cmp_new,
    output logic [W-1:0] res
);
    logic eq, lt, gt, tie;

    always_comb begin
        eq  = (s == t);
        lt  = $signed(s) < $signed(t);
        gt  = $signed(s) > $signed(t);
        tie = fl.ne & fl.co;
        cmp_new = fl.cmp;
        res     = t;
        case (op)
            OP_LT: begin
                cmp_new = lt | (eq & tie);
                res     = cmp_new ? s : t;
            end
            OP_GE: begin
                cmp_new = gt | (eq & ~tie);
                res     = cmp_new ? s : t;
            end
            OP_EQ: begin
                cmp_new = eq & ~fl.ne;
                res     = t;
            end
            OP_NE: begin
                cmp_new = ~eq | fl.ne;
                res     = s;
            end
            OP_MRG: begin
                cmp_new = fl.cmp;
                res     = fl.cmp ? s : t;
            end
            default: begin
                cmp_new = fl.cmp;
                res     = t;
            end
        endcase
    end
endmodule

// File: rtl/vcs_flag_bank.sv
module vcs_flag_bank
    import vcs_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [2:0]       op,
    input  logic [LANES-1:0] cmp_new,
    input  logic             load,
    input  logic [LANES-1:0] ne_in,
    input  logic [LANES-1:0] co_in,
    input  logic [LANES-1:0] cmp_in,
    input  logic [LANES-1:0] clip_in,
    output lane_flag_t       fl [LANES]
);
    logic commit_cmp;
    assign commit_cmp = valid && op_is_cmp(op);

    for (genvar i = 0; i < LANES; i++) begin : g_lane_fl
        always_ff @(posedge clk) begin
            if (rst) begin
                fl[i] <= '0;
            end else if (commit_cmp) begin
                fl[i].ne   <= 1'b0;
                fl[i].co   <= 1'b0;
                fl[i].clip <= 1'b0;
                fl[i].cmp  <= cmp_new[i];
            end else if (load && !valid) begin
                fl[i].ne   <= ne_in[i];
                fl[i].co   <= co_in[i];
                fl[i].cmp  <= cmp_in[i];
                fl[i].clip <= clip_in[i];
            end
        end

        p_flags_clear_r6: assert property (@(posedge clk) disable iff (rst)
            commit_cmp |=> (!fl[i].ne && !fl[i].co && !fl[i].clip));

        p_cmp_stored_r6: assert property (@(posedge clk) disable iff (rst)
            commit_cmp |=> (fl[i].cmp == $past(cmp_new[i])));

        p_merge_keeps_r1: assert property (@(posedge clk) disable iff (rst)
            (valid && op == OP_MRG) |=> $stable(fl[i]));

        p_load_r9: assert property (@(posedge clk) disable iff (rst)
            (load && !valid) |=> (fl[i].ne == $past(ne_in[i]) && fl[i].clip == $past(clip_in[i])));
    end

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (fl[0] == '0 && fl[LANES-1] == '0));
endmodule

// File: rtl/vcs_unit.sv
module vcs_unit
    import vcs_pkg::*;
#(
    parameter int LANES = 8,
    parameter int W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2:0]           in_op,
    input  logic [LANES*W-1:0]   src_s,
    input  logic [LANES*W-1:0]   src_t,
    input  logic                 flag_load,
    input  logic [LANES-1:0]     flag_ne_in,
    input  logic [LANES-1:0]     flag_co_in,
    input  logic [LANES-1:0]     flag_cmp_in,
    input  logic [LANES-1:0]     flag_clip_in,
    output logic [LANES*W-1:0]   dst_out,
    output logic [LANES*W-1:0]   acc_lo_out,
    output logic [LANES-1:0]     ne_flags,
    output logic [LANES-1:0]     co_flags,
    output logic [LANES-1:0]     cmp_flags,
    output logic [LANES-1:0]     clip_flags
);
    localparam int VW = LANES * W;

    lane_flag_t          fl [LANES];
    logic [LANES-1:0]    cmp_new;
    logic [VW-1:0]       res_vec;
    logic                commit;

    assign commit = in_valid && op_is_legal(in_op);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vcs_lane #(.W(W)) u_lane (
            .op      (in_op),
            .s       (src_s[i*W +: W]),
            .t       (src_t[i*W +: W]),
            .fl      (fl[i]),
            .cmp_new (cmp_new[i]),
            .res     (res_vec[i*W +: W])
        );
        assign ne_flags[i]   = fl[i].ne;
        assign co_flags[i]   = fl[i].co;
        assign cmp_flags[i]  = fl[i].cmp;
        assign clip_flags[i] = fl[i].clip;
    end

    vcs_flag_bank #(.LANES(LANES)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .valid   (in_valid),
        .op      (in_op),
        .cmp_new (cmp_new),
        .load    (flag_load),
        .ne_in   (flag_ne_in),
        .co_in   (flag_co_in),
        .cmp_in  (flag_cmp_in),
        .clip_in (flag_clip_in),
        .fl      (fl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_out    <= '0;
            acc_lo_out <= '0;
        end else if (commit) begin
            dst_out    <= res_vec;
            acc_lo_out <= res_vec;
        end
    end

    p_acc_mirror_r7: assert property (@(posedge clk) disable iff (rst)
        acc_lo_out == dst_out);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dst_out));

    p_eq_takes_t_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_EQ) |=> dst_out == $past(src_t));

    p_ne_takes_s_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_NE) |=> dst_out == $past(src_s));

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 3'd4) |=> ($stable(dst_out) && $stable(cmp_flags)
                                        && $stable(ne_flags) && $stable(clip_flags)));
endmodule

// File: tb/vcs_unit_bench.sv
module vcs_unit_bench;
    localparam int LANES = 8;
    localparam int W     = 16;
    localparam int VW    = LANES * W;

    // lanes 7..0: equal lanes 0,1,6,7; s<t lanes 2,4; s>t lanes 3,5
    localparam logic [VW-1:0] PS = 128'hFFFF_0000_7FFF_8000_0007_FFFD_0005_0005;
    localparam logic [VW-1:0] PT = 128'hFFFF_0000_8000_7FFF_FFFF_0002_0005_0005;
    localparam logic [7:0]    CLIP0 = 8'hC9;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] ne;
        logic [7:0] co;
        logic [7:0] cmp;
        logic [7:0] exp;
    } ent_t;

    localparam int NE = 14;
    localparam ent_t TBL [NE] = '{
        '{3'd0, 8'h00, 8'h00, 8'h66, 8'h14},
        '{3'd0, 8'hFF, 8'h0F, 8'h66, 8'h17},
        '{3'd0, 8'hC3, 8'h81, 8'h66, 8'h95},
        '{3'd0, 8'h00, 8'hFF, 8'h66, 8'h14},
        '{3'd3, 8'h00, 8'h00, 8'h66, 8'hEB},
        '{3'd3, 8'hFF, 8'h0F, 8'h66, 8'hE8},
        '{3'd3, 8'hF0, 8'hFF, 8'h66, 8'h2B},
        '{3'd1, 8'h00, 8'h00, 8'h66, 8'hC3},
        '{3'd1, 8'h41, 8'h00, 8'h66, 8'h82},
        '{3'd2, 8'h00, 8'h00, 8'h66, 8'h3C},
        '{3'd2, 8'h81, 8'h00, 8'h66, 8'hBD},
        '{3'd4, 8'h12, 8'h34, 8'h5A, 8'h5A},
        '{3'd4, 8'h00, 8'h00, 8'hFF, 8'hFF},
        '{3'd4, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [2:0] in_op;
    logic [VW-1:0] src_s, src_t;
    logic flag_load;
    logic [LANES-1:0] flag_ne_in, flag_co_in, flag_cmp_in, flag_clip_in;
    logic [VW-1:0] dst_out, acc_lo_out;
    logic [LANES-1:0] ne_flags, co_flags, cmp_flags, clip_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vcs_unit #(.LANES(LANES), .W(W)) u_vcs_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .src_s(src_s), .src_t(src_t), .flag_load(flag_load),
        .flag_ne_in(flag_ne_in), .flag_co_in(flag_co_in),
        .flag_cmp_in(flag_cmp_in), .flag_clip_in(flag_clip_in),
        .dst_out(dst_out), .acc_lo_out(acc_lo_out),
        .ne_flags(ne_flags), .co_flags(co_flags),
        .cmp_flags(cmp_flags), .clip_flags(clip_flags)
    );

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] pick(input logic [7:0] m, input logic [VW-1:0] s,
                                           input logic [VW-1:0] t);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*W +: W] = m[i] ? s[i*W +: W] : t[i*W +: W];
        return r;
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R3";
            default: return "R1";
        endcase
    endfunction

    task automatic preload(input logic [7:0] ne, input logic [7:0] co,
                           input logic [7:0] cmp, input logic [7:0] clip);
        @(negedge clk);
        flag_load = 1'b1; flag_ne_in = ne; flag_co_in = co;
        flag_cmp_in = cmp; flag_clip_in = clip;
        @(negedge clk);
        flag_load = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [VW-1:0] s, input logic [VW-1:0] t);
        in_valid = 1'b1; in_op = op; src_s = s; src_t = t;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] prev_d;
        rst = 1'b1; in_valid = 1'b0; in_op = 3'd0; src_s = '0; src_t = '0;
        flag_load = 1'b0; flag_ne_in = '0; flag_co_in = '0; flag_cmp_in = '0; flag_clip_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        check("R10 dst", dst_out, '0);
        check("R10 acc", acc_lo_out, '0);
        check("R10 flags", {ne_flags, co_flags, cmp_flags, clip_flags}, '0);

        // table walk: R1..R7, R11 via per-lane placement
        for (int k = 0; k < NE; k++) begin
            logic [VW-1:0] ed;
            preload(TBL[k].ne, TBL[k].co, TBL[k].cmp, CLIP0);
            run_op(TBL[k].op, PS, PT);
            case (TBL[k].op)
                3'd1:    ed = PT;
                3'd2:    ed = PS;
                default: ed = pick(TBL[k].exp, PS, PT);
            endcase
            check({op_req(TBL[k].op), " R11 dst"}, dst_out, ed);
            check("R7 acc", acc_lo_out, ed);
            if (TBL[k].op == 3'd4)
                check("R1 flags kept", {ne_flags, co_flags, cmp_flags, clip_flags},
                      {TBL[k].ne, TBL[k].co, TBL[k].cmp, CLIP0});
            else
                check({op_req(TBL[k].op), " R6 flags"}, {ne_flags, co_flags, cmp_flags, clip_flags},
                      {8'h00, 8'h00, TBL[k].exp, 8'h00});
        end

        // R7: idle cycles hold the result
        prev_d = dst_out;
        src_s = ~PS; src_t = ~PT;
        repeat (2) @(negedge clk);
        check("R7 hold", dst_out, prev_d);

        // R8: reserved op codes change nothing
        preload(8'hA1, 8'hB2, 8'hC3, 8'hD4);
        for (int op = 5; op < 8; op++) begin
            run_op(3'(op), PT, PS);
            check("R8 dst", dst_out, prev_d);
            check("R8 flags", {ne_flags, co_flags, cmp_flags, clip_flags},
                  {8'hA1, 8'hB2, 8'hC3, 8'hD4});
        end

        // R9: load ignored while a merge strobe is present
        in_valid = 1'b1; in_op = 3'd4; src_s = PS; src_t = PT;
        flag_load = 1'b1; flag_ne_in = 8'h0F; flag_co_in = 8'h0F;
        flag_cmp_in = 8'h0F; flag_clip_in = 8'h0F;
        @(negedge clk);
        in_valid = 1'b0; flag_load = 1'b0;
        check("R9 ignored", {ne_flags, co_flags, cmp_flags, clip_flags},
              {8'hA1, 8'hB2, 8'hC3, 8'hD4});
        check("R9 merge dst", dst_out, pick(8'hC3, PS, PT));

        // R2 edge: extreme values lane-wise
        preload(8'h00, 8'h00, 8'h00, 8'h00);
        run_op(3'd0, {8{16'h8000}}, {8{16'h7FFF}});
        check("R2 extreme", dst_out, {8{16'h8000}});

        // R10: reset mid-run clears everything
        preload(8'hFF, 8'hFF, 8'hFF, 8'hFF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid dst", dst_out, '0);
        check("R10 mid flags", {ne_flags, co_flags, cmp_flags, clip_flags}, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule